// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits beside a UART receiver and decides, for each completed character, whether the receive-complete flag should be raised. In the multiprocessor (multi-drop) arrangement several receivers share one line. The sender marks address characters by setting the ninth data bit. Each receiver uses this block to wake only for address characters meant for it, or for a broadcast address.

The block holds two 8-bit registers: a given address and an address mask. A mask bit of 1 makes the matching address bit significant. A mask bit of 0 makes it a don't-care. The broadcast address is the bitwise OR of the given address and the mask. Filtering is active only when the serial mode field is nonzero and multiprocessor mode is enabled. When filtering is off, every completed reception raises the flag. The output is a pulse in the same cycle as the receive-done strobe; the caller uses it to set its receive flag. Bit timing and shifting belong to the receiver and are not part of this block.

Top module: `uart_mp_filter`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears the given address and the address mask to 8'h00, visible on `given_addr` and `addr_mask` after the reset edge.
- R2: When `ser_mode` is 2'b00, every `rx_done` pulse produces `ri_set`, whatever the other inputs are.
- R3: When `multi_en` is 0, every `rx_done` pulse produces `ri_set`, whatever the other inputs are.
- R4: When filtering is active (`ser_mode` nonzero and `multi_en` 1), a character whose `rx_bit9` is 0 never produces `ri_set`.
- R5: When filtering is active and `rx_bit9` is 1, `ri_set` is raised when (given_addr AND addr_mask) equals (rx_data AND addr_mask).
- R6: When filtering is active and `rx_bit9` is 1, `ri_set` is raised when every bit that is 1 in (given_addr OR addr_mask) is also 1 in `rx_data`. Bits that are 0 in that broadcast value are don't-care, so 8'hFF always passes this test.
- R7: When filtering is active and neither R5 nor R6 holds, `ri_set` stays 0.
- R8: `ri_set` is high only in cycles where `rx_done` is high, so it lasts one cycle per one-cycle strobe.
- R9: `addr_we` loads `addr_wd` into the given address and `mask_we` loads `mask_wd` into the mask at the next clock edge, each independently. The new value applies to characters from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_we | input | 1 | Load strobe for the given address |
| addr_wd | input | 8 | New given address |
| mask_we | input | 1 | Load strobe for the address mask |
| mask_wd | input | 8 | New address mask |
| ser_mode | input | 2 | Serial mode field; 2'b00 disables filtering |
| multi_en | input | 1 | Multiprocessor mode enable |
| rx_done | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received byte |
| rx_bit9 | input | 1 | Received ninth bit |
| given_addr | output | 8 | Current given address register |
| addr_mask | output | 8 | Current address mask register |
| ri_set | output | 1 | Pulse that sets the receive flag |

## Verification
The bench targets the boundary between the two match rules. It uses bytes that fail the masked individual match but carry every 1 of the broadcast value, and bytes one bit short of it. A design that compared the broadcast value for strict equality would miss 8'hFF and similar bytes. A design that skipped the broadcast rule would drop them too. It also covers a zero mask with a zero address, where any address character must pass, and ninth-bit-zero data while filtering is active, which a design that ignores the ninth bit would let through. Last, it checks that the filter is bypassed for mode 0 and with multiprocessor mode off, that register loads are independent and take effect one cycle later, and that a mid-run reset returns both registers to zero.

// File: rtl/mpf_pkg.sv
// Package: shared types and helpers for the multiprocessor address filter.
// Assumes 2-bit serial mode encoding where 0 means the shift-register mode.
package mpf_pkg;

    typedef enum logic [1:0] {
        SER_SHIFT   = 2'b00,
        SER_8BIT    = 2'b01,
        SER_9BIT_FX = 2'b10,
        SER_9BIT_VR = 2'b11
    } ser_mode_e;

    // True when the given mode allows address filtering.
    function automatic logic mode_filters(input logic [1:0] m);
        return m != SER_SHIFT;
    endfunction

endpackage

// File: rtl/mpf_reg.sv
// Module: mpf_reg
// A W-bit holding register with load strobe, cleared to zero by a
// synchronous active-low reset. Assumes a single clock domain.
module mpf_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);

    // Hold value; load on strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wd;
    end

endmodule

// File: rtl/mpf_match.sv
// Module: mpf_match
// Pure comparator: masked individual-address match and broadcast match
// where zero bits of the broadcast value are don't-care. Combinational.
module mpf_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] own_addr,
    input  logic [W-1:0] own_mask,
    input  logic [W-1:0] cand,
    output logic         hit_indiv,
    output logic         hit_bcast
);

    localparam int LAST = W - 1;

    logic [W-1:0] bcast;
    logic [W-1:0] indiv_eq;
    logic [W-1:0] bcast_ok;

    // Broadcast value is the union of address and mask bits.
    always_comb bcast = own_addr | own_mask;

    // Per-bit compare: generated for every address bit.
    for (genvar b = 0; b <= LAST; b++) begin : g_bit
        assign indiv_eq[b] = !own_mask[b] || (own_addr[b] == cand[b]);
        assign bcast_ok[b] = !bcast[b] || cand[b];
    end

    // Reduce per-bit results into the two match flags.
    always_comb begin
        hit_indiv = &indiv_eq;
        hit_bcast = &bcast_ok;
    end

endmodule

// File: rtl/mpf_gate.sv
// Module: mpf_gate
// Decides whether a completed reception raises the receive flag.
// Assumes rx_done is a one-cycle strobe from the receiver.
module mpf_gate
    import mpf_pkg::*;
(
    input  logic       rx_done,
    input  logic [1:0] ser_mode,
    input  logic       multi_en,
    input  logic       rx_bit9,
    input  logic       hit_indiv,
    input  logic       hit_bcast,
    output logic       ri_set
);

    logic filtering;
    logic addr_ok;

    // Filter only when the mode allows it and multiprocessor mode is on.
    always_comb begin
        filtering = mode_filters(ser_mode) && multi_en;
        addr_ok   = rx_bit9 && (hit_indiv || hit_bcast);
        ri_set    = rx_done && (!filtering || addr_ok);
    end

endmodule

// File: rtl/uart_mp_filter.sv
// Module: uart_mp_filter (top)
// Holds the given address and mask and filters receive completions in
// multiprocessor mode. Output pulse is combinational from rx_done.
// Assumes synchronous active-low reset and one clock domain.
module uart_mp_filter #(
    parameter int W      = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [W-1:0]      addr_wd,
    input  logic              mask_we,
    input  logic [W-1:0]      mask_wd,
    input  logic [MODE_W-1:0] ser_mode,
    input  logic              multi_en,
    input  logic              rx_done,
    input  logic [W-1:0]      rx_data,
    input  logic              rx_bit9,
    output logic [W-1:0]      given_addr,
    output logic [W-1:0]      addr_mask,
    output logic              ri_set
);

    logic hit_indiv;
    logic hit_bcast;

    mpf_reg #(.W(W)) u_addr (
        .clk(clk), .rst_n(rst_n), .we(addr_we), .wd(addr_wd), .q(given_addr)
    );

    mpf_reg #(.W(W)) u_mask (
        .clk(clk), .rst_n(rst_n), .we(mask_we), .wd(mask_wd), .q(addr_mask)
    );

    mpf_match #(.W(W)) u_match (
        .own_addr(given_addr), .own_mask(addr_mask), .cand(rx_data),
        .hit_indiv(hit_indiv), .hit_bcast(hit_bcast)
    );

    mpf_gate u_gate (
        .rx_done(rx_done), .ser_mode(ser_mode[1:0]), .multi_en(multi_en),
        .rx_bit9(rx_bit9), .hit_indiv(hit_indiv), .hit_bcast(hit_bcast),
        .ri_set(ri_set)
    );

endmodule

// File: rtl/uart_mp_filter_chk.sv
// Module: uart_mp_filter_chk
// Assertion checker bound to uart_mp_filter; observes ports only.
module uart_mp_filter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         addr_we,
    input logic [W-1:0] addr_wd,
    input logic         mask_we,
    input logic [W-1:0] mask_wd,
    input logic [1:0]   ser_mode,
    input logic         multi_en,
    input logic         rx_done,
    input logic         rx_bit9,
    input logic [W-1:0] given_addr,
    input logic [W-1:0] addr_mask,
    input logic         ri_set
);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (given_addr == '0 && addr_mask == '0));

    p_mode0_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && ser_mode == 2'b00) |-> ri_set);

    p_sm_off_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !multi_en) |-> ri_set);

    p_data_frame_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && ser_mode != 2'b00 && multi_en && !rx_bit9) |-> !ri_set);

    p_pulse_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> !ri_set);

    p_addr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |=> (given_addr == $past(addr_wd)));

    p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (addr_mask == $past(mask_wd)));

endmodule

bind uart_mp_filter uart_mp_filter_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wd(addr_wd),
    .mask_we(mask_we), .mask_wd(mask_wd), .ser_mode(ser_mode[1:0]),
    .multi_en(multi_en), .rx_done(rx_done), .rx_bit9(rx_bit9),
    .given_addr(given_addr), .addr_mask(addr_mask), .ri_set(ri_set)
);

// File: tb/sim_uart_mp_filter.sv
// Bench for uart_mp_filter: vector table walk, then directed tests.
module sim_uart_mp_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_we = 1'b0, mask_we = 1'b0;
    logic [7:0] addr_wd = '0, mask_wd = '0;
    logic [1:0] ser_mode = '0;
    logic       multi_en = 1'b0;
    logic       rx_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_bit9 = 1'b0;
    logic [7:0] given_addr, addr_mask;
    logic       ri_set;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    uart_mp_filter u0 (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wd(addr_wd),
        .mask_we(mask_we), .mask_wd(mask_wd), .ser_mode(ser_mode),
        .multi_en(multi_en), .rx_done(rx_done), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .given_addr(given_addr), .addr_mask(addr_mask),
        .ri_set(ri_set)
    );

    // {mode, multi_en, bit9, data, addr, mask, expected ri_set}
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 8'h55, 8'hA0, 8'hF0, 1'b1}, // R2
        {2'd2, 1'b0, 1'b0, 8'h55, 8'hA0, 8'hF0, 1'b1}, // R3
        {2'd2, 1'b1, 1'b0, 8'hA5, 8'hA5, 8'hFF, 1'b0}, // R4
        {2'd2, 1'b1, 1'b1, 8'hA5, 8'hA5, 8'hFF, 1'b1}, // R5
        {2'd2, 1'b1, 1'b1, 8'hA4, 8'hA5, 8'hFF, 1'b0}, // R7
        {2'd2, 1'b1, 1'b1, 8'hA7, 8'hA5, 8'hF0, 1'b1}, // R5 masked
        {2'd2, 1'b1, 1'b1, 8'hB5, 8'hA5, 8'hF0, 1'b0}, // R7
        {2'd2, 1'b1, 1'b1, 8'hFF, 8'hA5, 8'hF0, 1'b1}, // R6
        {2'd2, 1'b1, 1'b1, 8'hF5, 8'hA5, 8'hF0, 1'b1}, // R6 exact
        {2'd1, 1'b1, 1'b1, 8'h7D, 8'h35, 8'hC0, 1'b0}, // R7 mode 1
        {2'd3, 1'b1, 1'b1, 8'hF7, 8'h35, 8'hC0, 1'b1}, // R6 don't-care
        {2'd2, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 1'b1}  // R5 zero mask
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_regs(input logic [7:0] a, input logic [7:0] m);
        @(negedge clk);
        addr_we = 1'b1; addr_wd = a;
        mask_we = 1'b1; mask_wd = m;
        @(negedge clk);
        addr_we = 1'b0; mask_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 addr after reset", given_addr, 8'h00);
        check("R1 mask after reset", addr_mask, 8'h00);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            load_regs(VEC[i][16:9], VEC[i][8:1]);
            ser_mode = VEC[i][28:27];
            multi_en = VEC[i][26];
            rx_bit9  = VEC[i][25];
            rx_data  = VEC[i][24:17];
            rx_done  = 1'b1;
            #1;
            check($sformatf("R2-7 vector %0d", i), {7'd0, ri_set}, {7'd0, VEC[i][0]});
            @(negedge clk);
            rx_done = 1'b0;
            #1;
            check($sformatf("R8 vector %0d idle", i), {7'd0, ri_set}, 8'h00);
        end

        // R8: matching character held but no strobe -> no pulse
        load_regs(8'h12, 8'hFF);
        ser_mode = 2'd2; multi_en = 1'b1; rx_bit9 = 1'b1; rx_data = 8'h12;
        @(negedge clk); #1;
        check("R8 no strobe", {7'd0, ri_set}, 8'h00);

        // R9: independent loads, effect next cycle
        @(negedge clk);
        addr_we = 1'b1; addr_wd = 8'h3C;
        @(negedge clk);
        addr_we = 1'b0;
        check("R9 addr loaded", given_addr, 8'h3C);
        check("R9 mask untouched", addr_mask, 8'hFF);
        mask_we = 1'b1; mask_wd = 8'h0F;
        @(negedge clk);
        mask_we = 1'b0;
        check("R9 mask loaded", addr_mask, 8'h0F);
        check("R9 addr untouched", given_addr, 8'h3C);
        // individual: 0C vs 0C -> match with new mask
        rx_data = 8'hAC; rx_done = 1'b1; #1;
        check("R9 new mask applies", {7'd0, ri_set}, 8'h01);
        @(negedge clk); rx_done = 1'b0;

        // R1: mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 addr after mid reset", given_addr, 8'h00);
        check("R1 mask after mid reset", addr_mask, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule